// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the register front end of a multichannel DMA controller supporting up to twelve channel engines. Software reaches it through a plain 32-bit register port addressed by word index. The block holds a transfer mode and a direction for each channel and drives them continuously to the engines. It also holds an interrupt enable for each channel. Each engine reports back a live two-bit activity code, a one-cycle completion pulse and a one-cycle fault pulse.

The channels are split into two groups, and each group has its own control word and its own status word. The lower group is channels 0 to 7 and the upper group is channels 8 to 11. Software sees which channels need service in the status words. It acknowledges them by writing a status word back, usually the same value it just read, which clears every pending bit that is 1 in that value. One interrupt line combines every pending, enabled channel.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset, every register reads zero, all channel mode and direction outputs are zero, and the interrupt output is low. The only exception is the activity-code bits of the status words, which follow the engine inputs.
- R2: Word 0 (byte offset 0x00) holds a 4-bit field for channel n < 8 at bits 4n+3..4n. Field bits [1:0] are the mode (0 off, 1 chained descriptors, 2 single descriptor) and drive that channel's mode output. Field bit 2 is the direction (1 memory-to-device, 0 device-to-memory) and drives its direction output. Field bit 3 always reads 0.
- R3: Word 3 (offset 0x0C) holds the same 4-bit layout for channels 8 to 11, with channel n at field n-8. Its fields 4 to 7 read 0.
- R4: Word 1 (offset 0x04) is a general 32-bit read/write register that affects nothing else.
- R5: Word 2 (offset 0x08) holds the interrupt enables: bit n for channel n < 8, and bit n+8 for channel n ≥ 8. All other bits read 0.
- R6: A completion pulse sets the channel's pending bit. This is bit n of word 4 (offset 0x10) for n < 8, and bit n-8 of word 6 (offset 0x18) for n ≥ 8.
- R7: A fault pulse sets both the pending bit and the fault bit. The fault bit is 8 places above the pending bit in the same status word.
- R8: Bits 2c+17..2c+16 of a status word show the live activity code of the group's channel c (0 idle, 1 fetching descriptor, 2 waiting, 3 moving data). Writes to these bits have no effect.
- R9: Writing a status word clears exactly the pending and fault bits that are 1 in the written value. Bits written as 0 are untouched, so writing back a value that was read clears what it showed.
- R10: If a pulse and a clearing write reach the same channel's bit in the same cycle, the bit ends up set.
- R11: The interrupt output is high exactly when some channel has its pending bit and its enable both set.
- R12: Words 5 and 7 read 0 and ignore writes. A write takes effect at the clock edge on which the write strobe is sampled, and reads return the current contents combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word | input | 3 | Register word index (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word, combinational |
| ch_mode | output | 2*NUM_CH | Mode per channel, channel n at bits 2n+1..2n |
| ch_dir | output | NUM_CH | Direction per channel |
| ch_state | input | 2*NUM_CH | Activity code per channel, channel n at bits 2n+1..2n |
| ch_done | input | NUM_CH | Completion pulse per channel |
| ch_err | input | NUM_CH | Fault pulse per channel |
| irq | output | 1 | Combined interrupt |

## Verification
A write presented with the strobe is committed at the next rising edge. The bench drives it on a falling edge and reads it back on the following falling edge. A pulse is raised for one falling-to-falling window, so the pending and fault bits and the interrupt output have settled by the next falling edge. The bench samples them there. Activity codes pass to the read port with no register, so they are checked one delay step after the input changes. Collisions between a pulse and a clearing write are driven in the same window, and the result is read one falling edge later.

// File: rtl/dma_csr_pkg.sv
`timescale 1ns/1ps
package dma_csr_pkg;
   localparam int MAX_CH   = 12;
   localparam int GRP_CH   = 8;
   localparam int FIELD_W  = 4;
   localparam int ERR_OFS  = 8;
   localparam int CODE_OFS = 16;

   localparam logic [2:0] W_CTL_LO = 3'd0;
   localparam logic [2:0] W_AUX    = 3'd1;
   localparam logic [2:0] W_IEN    = 3'd2;
   localparam logic [2:0] W_CTL_HI = 3'd3;
   localparam logic [2:0] W_STS_LO = 3'd4;
   localparam logic [2:0] W_STS_HI = 3'd6;

   typedef enum logic [1:0] {
      XFER_OFF    = 2'd0,
      XFER_CHAIN  = 2'd1,
      XFER_SINGLE = 2'd2
   } xfer_mode_e;

   function automatic int grp_slot(input int ch);
      return ch % GRP_CH;
   endfunction

   function automatic bit in_hi(input int ch);
      return ch >= GRP_CH;
   endfunction

   function automatic int ien_pos(input int ch);
      return (ch < GRP_CH) ? ch : ch + GRP_CH;
   endfunction
endpackage

// File: rtl/dma_csr_cfg.sv
`timescale 1ns/1ps
module dma_csr_cfg
   import dma_csr_pkg::*;
#(
   parameter int NUM_CH = 12,
   parameter int DATA_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_lo,
   input  logic                   wr_hi,
   input  logic                   wr_ien,
   input  logic                   wr_aux,
   input  logic [2*GRP_CH-1:0]    fld_mode,
   input  logic [GRP_CH-1:0]      fld_dir,
   input  logic [NUM_CH-1:0]      ien_wdata,
   input  logic [DATA_W-1:0]      aux_wdata,
   output logic [2*NUM_CH-1:0]    ch_mode,
   output logic [NUM_CH-1:0]      ch_dir,
   output logic [NUM_CH-1:0]      ien,
   output logic [DATA_W-1:0]      aux
);
   always_ff @(posedge clk) begin
      if (!rst_n)      aux <= '0;
      else if (wr_aux) aux <= aux_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ien <= '0;
      else if (wr_ien) ien <= ien_wdata;
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int  SLOT = grp_slot(ch);
      localparam bit  HI   = in_hi(ch);
      logic       wr_me;
      logic [1:0] mode_q;
      logic       dir_q;

      if (HI) begin : g_hi
         assign wr_me = wr_hi;
      end else begin : g_lo
         assign wr_me = wr_lo;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mode_q <= XFER_OFF;
            dir_q  <= 1'b0;
         end else if (wr_me) begin
            mode_q <= fld_mode[2*SLOT +: 2];
            dir_q  <= fld_dir[SLOT];
         end
      end

      assign ch_mode[2*ch +: 2] = mode_q;
      assign ch_dir[ch]         = dir_q;
   end
endmodule

// File: rtl/dma_csr_flag.sv
`timescale 1ns/1ps
module dma_csr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic done_pulse,
   input  logic err_pulse,
   input  logic clr_pend,
   input  logic clr_fault,
   output logic pend,
   output logic fault
);
   // set terms are ORed after the clear so a same-cycle event survives
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         fault <= 1'b0;
      end else begin
         pend  <= (pend  & ~clr_pend)  | done_pulse | err_pulse;
         fault <= (fault & ~clr_fault) | err_pulse;
      end
   end
endmodule

// File: rtl/dma_csr_rdmux.sv
`timescale 1ns/1ps
module dma_csr_rdmux
   import dma_csr_pkg::*;
#(
   parameter int NUM_CH = 12,
   parameter int DATA_W = 32
) (
   input  logic [2:0]           word,
   input  logic [DATA_W-1:0]    aux,
   input  logic [2*NUM_CH-1:0]  ch_mode,
   input  logic [NUM_CH-1:0]    ch_dir,
   input  logic [NUM_CH-1:0]    ien,
   input  logic [NUM_CH-1:0]    pend,
   input  logic [NUM_CH-1:0]    fault,
   input  logic [2*NUM_CH-1:0]  ch_state,
   output logic [DATA_W-1:0]    rdata
);
   logic [DATA_W-1:0] ctl_lo, ctl_hi, ien_v, sts_lo, sts_hi;

   always_comb begin
      ctl_lo = '0;
      ctl_hi = '0;
      ien_v  = '0;
      sts_lo = '0;
      sts_hi = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         int s;
         s = grp_slot(ch);
         ien_v[ien_pos(ch)] = ien[ch];
         if (in_hi(ch)) begin
            ctl_hi[FIELD_W*s +: 2]          = ch_mode[2*ch +: 2];
            ctl_hi[FIELD_W*s + 2]           = ch_dir[ch];
            sts_hi[s]                       = pend[ch];
            sts_hi[s + ERR_OFS]             = fault[ch];
            sts_hi[CODE_OFS + 2*s +: 2]     = ch_state[2*ch +: 2];
         end else begin
            ctl_lo[FIELD_W*s +: 2]          = ch_mode[2*ch +: 2];
            ctl_lo[FIELD_W*s + 2]           = ch_dir[ch];
            sts_lo[s]                       = pend[ch];
            sts_lo[s + ERR_OFS]             = fault[ch];
            sts_lo[CODE_OFS + 2*s +: 2]     = ch_state[2*ch +: 2];
         end
      end
   end

   always_comb begin
      unique case (word)
         W_CTL_LO: rdata = ctl_lo;
         W_AUX:    rdata = aux;
         W_IEN:    rdata = ien_v;
         W_CTL_HI: rdata = ctl_hi;
         W_STS_LO: rdata = sts_lo;
         W_STS_HI: rdata = sts_hi;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/dma_csr_bank.sv
`timescale 1ns/1ps
module dma_csr_bank
   import dma_csr_pkg::*;
#(
   parameter int NUM_CH = 12,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            bus_word,
   input  logic                  bus_wr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic [2*NUM_CH-1:0]   ch_mode,
   output logic [NUM_CH-1:0]     ch_dir,
   input  logic [2*NUM_CH-1:0]   ch_state,
   input  logic [NUM_CH-1:0]     ch_done,
   input  logic [NUM_CH-1:0]     ch_err,
   output logic                  irq
);
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("dma_csr_bank: NUM_CH must lie in 1..12");
   end
   if (DATA_W != 32) begin : g_bad_w
      $error("dma_csr_bank: DATA_W must be 32");
   end

   logic wr_ctl_lo, wr_ctl_hi, wr_ien, wr_aux, wr_sts_lo, wr_sts_hi;
   assign wr_ctl_lo = bus_wr && (bus_word == W_CTL_LO);
   assign wr_ctl_hi = bus_wr && (bus_word == W_CTL_HI);
   assign wr_ien    = bus_wr && (bus_word == W_IEN);
   assign wr_aux    = bus_wr && (bus_word == W_AUX);
   assign wr_sts_lo = bus_wr && (bus_word == W_STS_LO);
   assign wr_sts_hi = bus_wr && (bus_word == W_STS_HI);

   logic [2*GRP_CH-1:0] fld_mode;
   logic [GRP_CH-1:0]   fld_dir;
   for (genvar f = 0; f < GRP_CH; f++) begin : g_fld
      assign fld_mode[2*f +: 2] = bus_wdata[FIELD_W*f +: 2];
      assign fld_dir[f]         = bus_wdata[FIELD_W*f + 2];
   end

   logic [NUM_CH-1:0] ien_wdata, ien;
   logic [NUM_CH-1:0] clr_pend, clr_fault;
   logic [NUM_CH-1:0] irq_flag, err_flag;
   logic [DATA_W-1:0] aux;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int SLOT = grp_slot(ch);
      assign ien_wdata[ch] = bus_wdata[ien_pos(ch)];
      if (in_hi(ch)) begin : g_hi
         assign clr_pend[ch]  = wr_sts_hi & bus_wdata[SLOT];
         assign clr_fault[ch] = wr_sts_hi & bus_wdata[SLOT + ERR_OFS];
      end else begin : g_lo
         assign clr_pend[ch]  = wr_sts_lo & bus_wdata[SLOT];
         assign clr_fault[ch] = wr_sts_lo & bus_wdata[SLOT + ERR_OFS];
      end

      dma_csr_flag u_flag (
         .clk        (clk),
         .rst_n      (rst_n),
         .done_pulse (ch_done[ch]),
         .err_pulse  (ch_err[ch]),
         .clr_pend   (clr_pend[ch]),
         .clr_fault  (clr_fault[ch]),
         .pend       (irq_flag[ch]),
         .fault      (err_flag[ch])
      );
   end

   dma_csr_cfg #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (wr_ctl_lo),
      .wr_hi     (wr_ctl_hi),
      .wr_ien    (wr_ien),
      .wr_aux    (wr_aux),
      .fld_mode  (fld_mode),
      .fld_dir   (fld_dir),
      .ien_wdata (ien_wdata),
      .aux_wdata (bus_wdata),
      .ch_mode   (ch_mode),
      .ch_dir    (ch_dir),
      .ien       (ien),
      .aux       (aux)
   );

   dma_csr_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
      .word     (bus_word),
      .aux      (aux),
      .ch_mode  (ch_mode),
      .ch_dir   (ch_dir),
      .ien      (ien),
      .pend     (irq_flag),
      .fault    (err_flag),
      .ch_state (ch_state),
      .rdata    (bus_rdata)
   );

   assign irq = |(irq_flag & ien);
endmodule

// File: rtl/dma_csr_bank_chk.sv
`timescale 1ns/1ps
module dma_csr_bank_chk
   import dma_csr_pkg::*;
#(
   parameter int NUM_CH = 12,
   parameter int DATA_W = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [2:0]            bus_word,
   input logic                  bus_wr,
   input logic [DATA_W-1:0]     bus_wdata,
   input logic [DATA_W-1:0]     bus_rdata,
   input logic [2*NUM_CH-1:0]   ch_mode,
   input logic [2*NUM_CH-1:0]   ch_state,
   input logic [NUM_CH-1:0]     ch_done,
   input logic [NUM_CH-1:0]     ch_err,
   input logic [NUM_CH-1:0]     irq_flag,
   input logic [NUM_CH-1:0]     err_flag,
   input logic [NUM_CH-1:0]     ien,
   input logic                  irq
);
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int SLOT = grp_slot(ch);
      localparam logic [2:0] SW = in_hi(ch) ? W_STS_HI : W_STS_LO;

      // R6
      done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ch_done[ch] |=> irq_flag[ch]);

      // R7
      err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ch_err[ch] |=> (irq_flag[ch] && err_flag[ch]));

      // R9
      pend_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq_flag[ch]) |->
            $past(bus_wr && bus_word == SW && bus_wdata[SLOT]));
   end

   // R2
   mode_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ch_mode) |->
         $past(bus_wr && (bus_word == W_CTL_LO || bus_word == W_CTL_HI)));

   // R8
   code_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_word == W_STS_LO) |-> (bus_rdata[CODE_OFS +: 2] == ch_state[1:0]));

   // R11
   irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|ien));

   // R11
   irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |->
         ($past(|(ch_done | ch_err)) || $past(bus_wr && bus_word == W_IEN)));

   // R12
   resv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_word == 3'd5 || bus_word == 3'd7) |-> (bus_rdata == '0));
endmodule

bind dma_csr_bank dma_csr_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_word  (bus_word),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .ch_mode   (ch_mode),
   .ch_state  (ch_state),
   .ch_done   (ch_done),
   .ch_err    (ch_err),
   .irq_flag  (irq_flag),
   .err_flag  (err_flag),
   .ien       (ien),
   .irq       (irq)
);

// File: tb/tb_dma_csr_bank.sv
`timescale 1ns/1ps
module tb_dma_csr_bank;
   localparam int N = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    bus_word = '0;
   logic          bus_wr = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [2*N-1:0] ch_mode;
   logic [N-1:0]  ch_dir;
   logic [2*N-1:0] ch_state = '0;
   logic [N-1:0]  ch_done = '0;
   logic [N-1:0]  ch_err = '0;
   logic          irq;

   int vectors = 0;
   int miscompares = 0;

   logic [1:0] m_mode [N];
   logic       m_dir  [N];
   logic       m_pend [N];
   logic       m_flt  [N];
   logic [N-1:0] m_ien;
   logic [31:0]  m_aux;

   always #4 clk = ~clk;

   dma_csr_bank #(.NUM_CH(N)) dut (
      .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_mode(ch_mode),
      .ch_dir(ch_dir), .ch_state(ch_state), .ch_done(ch_done),
      .ch_err(ch_err), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input int w);
      logic [31:0] v = '0;
      for (int ch = 0; ch < N; ch++) begin
         int s = ch % 8;
         bit hi = (ch >= 8);
         if ((w == 0 && !hi) || (w == 3 && hi)) begin
            v[4*s +: 2] = m_mode[ch];
            v[4*s + 2]  = m_dir[ch];
         end
         if ((w == 4 && !hi) || (w == 6 && hi)) begin
            v[s]            = m_pend[ch];
            v[s + 8]        = m_flt[ch];
            v[16 + 2*s +: 2] = ch_state[2*ch +: 2];
         end
         if (w == 2) v[hi ? ch + 8 : ch] = m_ien[ch];
      end
      if (w == 1) v = m_aux;
      return v;
   endfunction

   function automatic logic exp_irq();
      logic r = 1'b0;
      for (int ch = 0; ch < N; ch++) r |= m_pend[ch] & m_ien[ch];
      return r;
   endfunction

   task automatic model_write(input int w, input logic [31:0] d);
      for (int ch = 0; ch < N; ch++) begin
         int s = ch % 8;
         bit hi = (ch >= 8);
         if ((w == 0 && !hi) || (w == 3 && hi)) begin
            m_mode[ch] = d[4*s +: 2];
            m_dir[ch]  = d[4*s + 2];
         end
         if ((w == 4 && !hi) || (w == 6 && hi)) begin
            if (d[s])     m_pend[ch] = 1'b0;
            if (d[s + 8]) m_flt[ch]  = 1'b0;
         end
         if (w == 2) m_ien[ch] = d[hi ? ch + 8 : ch];
      end
      if (w == 1) m_aux = d;
   endtask

   task automatic bus_write(input int w, input logic [31:0] d);
      @(negedge clk);
      bus_word = 3'(w); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(w, d);
   endtask

   task automatic bus_read(input int w, output logic [31:0] d);
      bus_word = 3'(w);
      #1;
      d = bus_rdata;
   endtask

   task automatic check_word(input string req, input int w);
      logic [31:0] d;
      bus_read(w, d);
      check(req, d, exp_word(w));
   endtask

   task automatic check_outputs(input string req);
      logic [2*N-1:0] em;
      logic [N-1:0]   ed;
      for (int ch = 0; ch < N; ch++) begin
         em[2*ch +: 2] = m_mode[ch];
         ed[ch] = m_dir[ch];
      end
      check({req, " mode"}, 32'(ch_mode), 32'(em));
      check({req, " dir"},  32'(ch_dir),  32'(ed));
      check({req, " irq"},  32'(irq),     32'(exp_irq()));
   endtask

   task automatic pulse(input int ch, input bit is_err);
      @(negedge clk);
      if (is_err) ch_err[ch] = 1'b1; else ch_done[ch] = 1'b1;
      @(negedge clk);
      ch_err = '0; ch_done = '0;
      m_pend[ch] = 1'b1;
      if (is_err) m_flt[ch] = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      for (int ch = 0; ch < N; ch++) begin
         m_mode[ch] = '0; m_dir[ch] = 0; m_pend[ch] = 0; m_flt[ch] = 0;
      end
      m_ien = '0; m_aux = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state of every word and output
      for (int w = 0; w < 8; w++) check_word("R1 reset word", w);
      check_outputs("R1 reset");

      // R2 / R3: sweep each channel through every mode and direction
      for (int ch = 0; ch < N; ch++)
         for (int m = 0; m < 3; m++)
            for (int d = 0; d < 2; d++) begin
               int w = (ch >= 8) ? 3 : 0;
               logic [31:0] v = '0;
               v[4*(ch % 8) +: 3] = 3'(d * 4 + m);
               v[4*(ch % 8) + 3]  = 1'b1;
               bus_write(w, v);
               check_word(ch >= 8 ? "R3 ctl hi" : "R2 ctl lo", w);
               check_outputs(ch >= 8 ? "R3" : "R2");
            end
      bus_write(0, 32'hFFFF_FFFF);
      bus_write(3, 32'hFFFF_FFFF);
      check_word("R2 all ones", 0);
      check_word("R3 all ones", 3);
      check("R3 upper fields", bus_rdata & 32'hFFFF_0000, 32'h0);

      // R4: general register patterns
      for (int k = 0; k < 6; k++) begin
         bus_write(1, 32'hA5C3_0F01 ^ (32'h1357_9BDF * k));
         check_word("R4 aux", 1);
         check_word("R4 ctl untouched", 0);
      end

      // R12: reserved words
      bus_write(5, 32'hFFFF_FFFF);
      bus_write(7, 32'hFFFF_FFFF);
      check_word("R12 word5", 5);
      check_word("R12 word7", 7);
      check_word("R12 aux intact", 1);

      // R5: enable placement
      bus_write(2, 32'hFFFF_FFFF);
      check_word("R5 ien all", 2);
      check("R5 ien mask", bus_rdata, 32'h000F_00FF);

      // R6 R7 R9 R10 R11: per-channel flag sweep
      for (int ch = 0; ch < N; ch++) begin
         int w = (ch >= 8) ? 6 : 4;
         pulse(ch, 0);
         check_word("R6 done sets pend", w);
         check("R11 irq on pend", 32'(irq), 32'(exp_irq()));
         bus_write(w, 32'h0);
         check_word("R9 zero write keeps", w);
         bus_read(w, rd);
         bus_write(w, rd);
         check_word("R9 write-back clears", w);
         check("R11 irq after clear", 32'(irq), 32'(exp_irq()));
         pulse(ch, 1);
         check_word("R7 err sets both", w);
         // R10: pulse and clear in the same cycle
         @(negedge clk);
         ch_err[ch] = 1'b1;
         bus_word = 3'(w); bus_wdata = 32'h0000_FFFF; bus_wr = 1'b1;
         @(negedge clk);
         ch_err = '0; bus_wr = 1'b0;
         check_word("R10 pulse beats clear", w);
         bus_write(w, 32'h0000_FFFF);
         check_word("R9 full clear", w);
      end

      // R11: enable gating
      bus_write(2, 32'h0);
      pulse(5, 0);
      check("R11 masked", 32'(irq), 32'(exp_irq()));
      bus_write(2, 32'h0000_0020);
      check("R11 enabled", 32'(irq), 32'(exp_irq()));
      bus_write(2, 32'h0001_0000);
      pulse(8, 0);
      check("R11 hi enabled", 32'(irq), 32'(exp_irq()));
      bus_write(4, 32'hFF);
      bus_write(6, 32'hFF);
      check("R11 all clear", 32'(irq), 32'(exp_irq()));

      // R8: activity codes and ignored writes
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         ch_state = 24'(32'h9E37_79B9 * (k + 1));
         check_word("R8 code lo", 4);
         check_word("R8 code hi", 6);
         bus_write(4, 32'hFFFF_0000);
         bus_write(6, 32'hFFFF_0000);
         check_word("R8 write ignored lo", 4);
         check_word("R8 write ignored hi", 6);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule